// File: doc/BRIEF.md
# Single-Line Non-Maskable Interrupt Controller

This block watches one external non-maskable interrupt pin and turns a chosen condition on that pin into a latched request for a parent interrupt controller. The pin is synchronised into the core clock domain first. One of four trigger conditions is then applied to it: active-high level, active-low level, rising edge or falling edge. When the condition is met, a sticky pending flag is set. The request output is raised only while that flag is set and software has enabled the line.

Software controls the block through a small register port with three 32-bit words: a control word holding the trigger code, a pending word whose bit 0 is cleared by writing a one, and an enable word whose bit 0 gates the output. A build parameter selects one of three address layouts, so the same block can fit different memory maps. The register port is a simple select, write-enable, address and data interface, and read data is returned in the same cycle.

In the level modes, software acknowledges the request after the service routine. In the edge modes, it acknowledges the request before handling it. The pending logic therefore lets a level that is still active set the flag again at once, and lets an edge set it only once for each transition.

Top module: `nmi_line_ctrl`

## Requirements
- R1: Control bits [1:0] choose the trigger: code 0 = pin low (level), 1 = high-to-low transition, 2 = pin high (level), 3 = low-to-high transition.
- R2: A write to the control word stores all 32 bits, and reads return the last value written. Only bits [1:0] affect behaviour.
- R3: The pending word reads back the flag in bit 0 and zeros above it. A write with bit 0 = 1 clears the flag. A write with bit 0 = 0 leaves it unchanged.
- R4: The enable word holds one bit in position 0, and its upper bits read as zero. `irq_out` is high exactly when the pending flag and the enable bit are both set.
- R5: Parameter LAYOUT picks the offsets. Layout 0: control 0x00, pending 0x04, enable 0x34. Layout 1 (default): control 0x00, pending 0x04, enable 0x08. Layout 2: control 0x00, enable 0x04, pending 0x08.
- R6: In the level modes, if the level is still active, the pending flag reads as set right after a clear write.
- R7: In the edge modes, one pin transition sets the flag once. After a clear, the flag stays clear while the pin holds its level.
- R8: When a trigger event and a clear write fall in the same cycle, the event wins and the flag stays set.
- R9: After reset, control, enable and pending all read 0 and `irq_out` is low. The synchroniser resets to the high (idle) level, so a high pin causes no event after reset.
- R10: Reads of any unmapped offset return 0. Writes to unmapped offsets change no register.
- R11: A pin change driven before clock edge 1 is seen in the pending flag after edge 3 (two synchroniser stages plus the flag register), and not after edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Asynchronous external interrupt pin |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | 1 | Request to the parent controller |

## Verification
The assertions assume that a register access lasts exactly one cycle with a stable address and data. They also assume that the pin's only effect reaches the core through the synchroniser, so the checks do not depend on the pin timing. The stimulus drives every access and every pin change on the falling clock edge and holds each write for a single cycle. Pin changes are spaced several cycles apart, except in the deliberate same-cycle collision case, which is timed to the edge count given in R11.

// File: rtl/nmi_line_pkg.sv
// Package: shared types and the address-layout table for the NMI line controller.
// Assumes LAYOUT is 0, 1 or 2; any other value falls back to layout 1.
package nmi_line_pkg;

    localparam int unsigned DATA_W = 32;

    // Trigger codes; the numbering is fixed by the programming model.
    typedef enum logic [1:0] {
        TRIG_LVL_LO    = 2'd0,
        TRIG_EDGE_FALL = 2'd1,
        TRIG_LVL_HI    = 2'd2,
        TRIG_EDGE_RISE = 2'd3
    } trig_mode_e;

    // Byte offset of the control word for a layout.
    function automatic int unsigned ctrl_offset(input int unsigned layout);
        ctrl_offset = 32'h00 + 0 * layout;
    endfunction

    // Byte offset of the pending word for a layout.
    function automatic int unsigned pend_offset(input int unsigned layout);
        pend_offset = (layout == 2) ? 32'h08 : 32'h04;
    endfunction

    // Byte offset of the enable word for a layout.
    function automatic int unsigned en_offset(input int unsigned layout);
        case (layout)
            0:       en_offset = 32'h34;
            2:       en_offset = 32'h04;
            default: en_offset = 32'h08;
        endcase
    endfunction

endpackage

// File: rtl/nmi_sync.sv
// Module: multi-stage synchroniser for the asynchronous interrupt pin.
// Assumes STAGES >= 2. Every stage resets to RST_VAL so that the
// idle pin level produces no spurious event after reset.
module nmi_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Stage 0 captures the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= RST_VAL;
        else        chain_q[0] <= async_in;
    end

    // Remaining stages shift the captured value through.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= RST_VAL;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/nmi_trig_detect.sv
// Module: applies the selected trigger condition to the synchronised pin.
// Assumes level_in is already in the clk domain. The previous-value flop
// resets to RST_VAL to match the synchroniser reset level.
module nmi_trig_detect
    import nmi_line_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_in,
    input  trig_mode_e mode,
    output logic       event_o
);

    logic prev_q;
    logic rise_w;
    logic fall_w;

    // Holds the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level_in;
    end

    assign rise_w = level_in & ~prev_q;
    assign fall_w = ~level_in & prev_q;

    // Selects the active condition from the trigger code.
    always_comb begin
        case (mode)
            TRIG_LVL_LO:    event_o = ~level_in;
            TRIG_EDGE_FALL: event_o = fall_w;
            TRIG_LVL_HI:    event_o = level_in;
            TRIG_EDGE_RISE: event_o = rise_w;
            default:        event_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/nmi_regs.sv
// Module: register decode plus the control, enable and pending state.
// Assumes single-cycle accesses. Offsets come from the layout table in
// the package. An event takes priority over a clear in the same cycle.
module nmi_regs
    import nmi_line_pkg::*;
#(
    parameter int unsigned LAYOUT = 1,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              event_i,
    output trig_mode_e        mode_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              pend_o,
    output logic              en_o
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(ctrl_offset(LAYOUT));
    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(pend_offset(LAYOUT));
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(en_offset(LAYOUT));

    logic [DATA_W-1:0] ctrl_q;
    logic              pend_q;
    logic              en_q;
    logic              hit_ctrl;
    logic              hit_pend;
    logic              hit_en;
    logic              clr_w;

    assign hit_ctrl = reg_sel & (reg_addr == CTRL_A);
    assign hit_pend = reg_sel & (reg_addr == PEND_A);
    assign hit_en   = reg_sel & (reg_addr == EN_A);
    assign clr_w    = hit_pend & reg_we & reg_wdata[0];

    // Control word: stores every bit written, for read-modify-write.
    always_ff @(posedge clk) begin
        if (!rst_n)                ctrl_q <= '0;
        else if (hit_ctrl && reg_we) ctrl_q <= reg_wdata;
    end

    // Enable bit: gates the request output.
    always_ff @(posedge clk) begin
        if (!rst_n)                en_q <= 1'b0;
        else if (hit_en && reg_we) en_q <= reg_wdata[0];
    end

    // Pending flag: set by an event, cleared by a one written to bit 0; the event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= event_i | (pend_q & ~clr_w);
    end

    // Read multiplexer: unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl)      reg_rdata = ctrl_q;
        else if (hit_pend) reg_rdata = {{(DATA_W-1){1'b0}}, pend_q};
        else if (hit_en)   reg_rdata = {{(DATA_W-1){1'b0}}, en_q};
    end

    assign mode_o = trig_mode_e'(ctrl_q[1:0]);
    assign ctrl_o = ctrl_q;
    assign pend_o = pend_q;
    assign en_o   = en_q;

endmodule

// File: rtl/nmi_line_ctrl.sv
// Module: top of the single-line NMI controller. It chains the synchroniser,
// the trigger detector and the register block. Assumes nmi_pin is
// asynchronous to clk and that the pin idles high during reset.
module nmi_line_ctrl
    import nmi_line_pkg::*;
#(
    parameter int unsigned LAYOUT      = 1,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_out
);

    localparam logic IDLE_LVL = 1'b1;

    logic              pin_sync;
    logic              trig_evt;
    trig_mode_e        mode_w;
    logic [DATA_W-1:0] ctrl_w;
    logic              pend_w;
    logic              en_w;

    nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (nmi_pin),
        .sync_out (pin_sync)
    );

    nmi_trig_detect #(.RST_VAL(IDLE_LVL)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (pin_sync),
        .mode     (mode_w),
        .event_o  (trig_evt)
    );

    nmi_regs #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .event_i   (trig_evt),
        .mode_o    (mode_w),
        .ctrl_o    (ctrl_w),
        .pend_o    (pend_w),
        .en_o      (en_w)
    );

    assign irq_out = pend_w & en_w;

endmodule

// File: rtl/nmi_line_chk.sv
// Module: assertion checker bound to nmi_line_ctrl. It relates register
// state to the bus accesses and the detected events over time.
module nmi_line_chk
    import nmi_line_pkg::*;
#(
    parameter int unsigned LAYOUT = 1,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              irq_out,
    input logic              trig_evt,
    input logic [31:0]       ctrl_w,
    input logic              pend_w,
    input logic              en_w
);

    localparam logic [ADDR_W-1:0] C_A = ADDR_W'(ctrl_offset(LAYOUT));
    localparam logic [ADDR_W-1:0] P_A = ADDR_W'(pend_offset(LAYOUT));
    localparam logic [ADDR_W-1:0] E_A = ADDR_W'(en_offset(LAYOUT));

    logic wr_c, wr_p1, wr_e;
    assign wr_c  = reg_sel && reg_we && (reg_addr == C_A);
    assign wr_p1 = reg_sel && reg_we && (reg_addr == P_A) && reg_wdata[0];
    assign wr_e  = reg_sel && reg_we && (reg_addr == E_A);

    // R3: the flag only falls after a clearing write.
    a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_w) |-> $past(wr_p1));

    // R8: an event in the cycle of a clear keeps the flag set.
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_evt && wr_p1) |=> pend_w);

    // R1: the flag only rises after a detected event.
    a_r1_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_w) |-> $past(trig_evt));

    // R4: a masked line never requests.
    a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !en_w |-> !irq_out);

    // R10: control and enable change only through their own write.
    a_r10_ctrl_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_w) |-> $past(wr_c));

    a_r10_en_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_w) |-> $past(wr_e));

    // R9: first cycle out of reset shows the reset state.
    a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctrl_w == 32'h0 && !en_w && !irq_out));

endmodule

bind nmi_line_ctrl nmi_line_chk #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_out   (irq_out),
    .trig_evt  (trig_evt),
    .ctrl_w    (ctrl_w),
    .pend_w    (pend_w),
    .en_w      (en_w)
);

// File: tb/sim_nmi_line_ctrl.sv
`timescale 1ns/1ps
module sim_nmi_line_ctrl;

    localparam int unsigned AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nmi_pin = 1'b1;
    logic          reg_sel = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   rdata0, rdata1;
    logic          irq0, irq1;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    nmi_line_ctrl #(.LAYOUT(1), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .reg_sel(reg_sel),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata0), .irq_out(irq0)
    );

    nmi_line_ctrl #(.LAYOUT(2), .ADDR_W(AW)) u1 (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .reg_sel(reg_sel),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata1), .irq_out(irq1)
    );

    // Monitor: pops expectations and compares away from the active edge.
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = rdata0;
                1:       act = {31'b0, irq0};
                default: act = rdata1;
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd_push(input int k, input logic [AW-1:0] a,
                           input logic [31:0] e, input string t);
        item_t it;
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        it.kind = k; it.exp = e; it.tag = t;
        sb_q.push_back(it);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
        rd_push(0, a, e, t);
    endtask

    task automatic irq_chk(input logic e, input string t);
        item_t it;
        @(negedge clk);
        it.kind = 1; it.exp = {31'b0, e}; it.tag = t;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_set(input logic v);
        @(negedge clk);
        nmi_pin = v;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Driver: u0 uses layout 1 (ctrl 0x00, pend 0x04, en 0x08).
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        rd(8'h00, 32'h0, "R9 ctrl reset");
        rd(8'h04, 32'h0, "R9 pend reset");
        rd(8'h08, 32'h0, "R9 en reset");
        irq_chk(1'b0, "R9 irq reset");

        wr(8'h00, 32'h1234_5670);
        rd(8'h00, 32'h1234_5670, "R2 ctrl readback");
        idle(4);
        rd(8'h04, 32'h0, "R1 level-low idle with pin high");

        wr(8'h00, 32'hCAFE_0002);
        idle(4);
        rd(8'h04, 32'h1, "R1 level-high sets pending");
        irq_chk(1'b0, "R4 masked output");
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h1, "R4 enable reads bit0 only");
        irq_chk(1'b1, "R4 output when pending and enabled");

        wr(8'h04, 32'hFFFF_FFFE);
        rd(8'h04, 32'h1, "R3 writing zero keeps pending");
        wr(8'h04, 32'h1);
        rd(8'h04, 32'h1, "R6 level still high re-pends");

        pin_set(1'b0);
        idle(4);
        wr(8'h04, 32'h1);
        rd(8'h04, 32'h0, "R3 write one clears");
        irq_chk(1'b0, "R4 output drops with pending");

        wr(8'h08, 32'h0);
        wr(8'h00, 32'h0);
        idle(4);
        rd(8'h04, 32'h1, "R1 level-low sets pending");
        wr(8'h04, 32'h1);
        rd(8'h04, 32'h1, "R6 level-low re-pends");

        wr(8'h00, 32'h3);
        idle(2);
        wr(8'h04, 32'h1);
        rd(8'h04, 32'h0, "R1 rising mode ignores low level");
        pin_set(1'b1);
        rd(8'h04, 32'h0, "R11 not seen after one edge");
        rd(8'h04, 32'h0, "R11 not seen after two edges");
        rd(8'h04, 32'h1, "R11 seen after three edges");
        wr(8'h04, 32'h1);
        idle(4);
        rd(8'h04, 32'h0, "R7 rising edge pends once");

        pin_set(1'b0);
        idle(4);
        pin_set(1'b1);
        idle(4);
        pin_set(1'b0);
        idle(4);
        rd(8'h04, 32'h1, "R7 second rise pends");
        pin_set(1'b1);
        @(negedge clk);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h1;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
        rd(8'h04, 32'h1, "R8 event beats same-cycle clear");
        wr(8'h04, 32'h1);
        rd(8'h04, 32'h0, "R8 later clear works");

        wr(8'h00, 32'h1);
        idle(2);
        wr(8'h04, 32'h1);
        rd(8'h04, 32'h0, "R1 falling mode idle");
        pin_set(1'b0);
        idle(4);
        rd(8'h04, 32'h1, "R1 falling edge sets pending");
        wr(8'h04, 32'h1);
        idle(3);
        rd(8'h04, 32'h0, "R7 falling edge pends once");

        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h34, 32'h0, "R10 unmapped 0x34 reads zero");
        rd(8'h10, 32'h0, "R10 unmapped 0x10 reads zero");
        rd(8'h0C, 32'h0, "R10 unmapped 0x0C reads zero");
        rd(8'h00, 32'h1, "R10 ctrl untouched");
        rd(8'h08, 32'h0, "R10 enable untouched");

        wr(8'h04, 32'h0);
        rd_push(2, 8'h04, 32'h0, "R5 layout 2 enable at 0x04 cleared");
        wr(8'h04, 32'h1);
        rd_push(2, 8'h04, 32'h1, "R5 layout 2 enable at 0x04 set");
        rd_push(2, 8'h34, 32'h0, "R5 layout 2 has nothing at 0x34");

        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule